// File: doc/BRIEF.md
# Asynchronous Static RAM Access Sequencer

This block sits between a synchronous host and an external asynchronous static RAM with a 16-bit data bus, two chip selects (one active low, one active high), an active-low output enable, an active-low write enable and one active-low enable per byte lane. The host hands over single-beat read or write requests on a valid/ready port. Each request carries an address, 16 bits of write data and a 2-bit lane mask. The sequencer turns each request into a pin sequence whose intervals are counted in clock cycles. Every interval is a parameter equal to the nanosecond limit divided by the clock period, rounded up.

A read selects the memory, lowers output enable and holds the address for the longer of the address-access and output-enable-access intervals. It samples the bus at the end of that window and returns the word with a one-cycle valid pulse. A write lowers write enable with output enable high. It waits a turnaround interval before it drives the bus, keeps the data on the bus long enough for both the setup and the pulse-width limits, and ends the write with the rising edge of write enable. Address, data and lane enables then stay put for a hold interval. After a read, the memory stays deselected for a gap interval before any further access can begin.

Top module: `sram_seq_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, `sram_cs1_n` is 1, `sram_cs2` is 0, `sram_oe_n` and `sram_we_n` are 1, and `sram_dq_oe` is 0.
- R2: A request is taken only when `req_valid` and `req_ready` are both 1 at a clock edge. `req_ready` is 0 from the edge that takes a request until the access and its trailing interval are over, and any request offered while `req_ready` is 0 has no effect on memory.
- R3: A read holds the address with `sram_oe_n`=0, `sram_we_n`=1 and both lane enables low for RD_WAIT = max(AA_CYC, OE_CYC) cycles. The bus is sampled at the edge that ends that window. `rsp_rdata` carries the sample while `rsp_valid` is 1 for exactly one cycle, RD_WAIT cycles after the edge that took the request.
- R4: During a write, `sram_oe_n` stays 1. `sram_dq_oe` rises only after `sram_we_n` has been 0 for at least TURN_CYC cycles.
- R5: `sram_we_n` stays low for at least WEPW_CYC cycles, and write data is driven for at least DS_CYC cycles before `sram_we_n` rises.
- R6: Each write ends with the rising edge of `sram_we_n`. For WH_CYC cycles after that edge, the address, the data, the lane enables and the chip selects stay unchanged and `sram_dq_oe` stays 1.
- R7: Lane mask bit 0 selects bits 7:0 and drives `sram_lb_n` low. Mask bit 1 selects bits 15:8 and drives `sram_ub_n` low. Lanes whose mask bit is 0 keep their stored value, and a mask of 0 changes nothing.
- R8: After a read, the memory stays deselected for at least GAP_CYC+1 cycles before the next access selects it. Any two accesses are separated by at least one deselected cycle.
- R9: `sram_dq_oe` is never 1 while `sram_oe_n` is 0.
- R10: `sram_cs1_n` is always the inverse of `sram_cs2`. Both are in the selected state for the whole of every access and in the deselected state when idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Lane mask, bit 0 low byte, bit 1 high byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Captured read data |
| sram_addr | output | ADDR_W | Memory address pins |
| sram_cs1_n | output | 1 | Active-low chip select |
| sram_cs2 | output | 1 | Active-high chip select |
| sram_oe_n | output | 1 | Active-low output enable |
| sram_we_n | output | 1 | Active-low write enable |
| sram_lb_n | output | 1 | Active-low low-byte enable |
| sram_ub_n | output | 1 | Active-low high-byte enable |
| sram_dq_o | output | 16 | Data toward the memory |
| sram_dq_oe | output | 1 | Drive enable for `sram_dq_o` |
| sram_dq_i | input | 16 | Data from the memory |

## Verification
The hardest case to reach from the ports is a sampling edge that is off by one cycle. A design that samples one cycle early still returns a plausible word whenever the memory holds the same value long enough. The bench memory model therefore returns a poison word until output enable and the address have been held for the full access window, so an early sample shows up as a data mismatch. The bench also places a write directly after a read, so the gap and turnaround counts are measured on the pins. It offers requests while the sequencer is busy and then reads that address back, to show the offers were dropped.

// File: rtl/sram_seq_pkg.sv
package sram_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_RD_GAP,
        ST_WR_TURN,
        ST_WR_DATA,
        ST_WR_HOLD
    } seq_state_e;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_seq_timer.sv
module sram_seq_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);

    // Timer never wraps below zero
    p_timer_no_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/sram_seq_rdcap.sv
module sram_seq_rdcap #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic              valid,
    output logic [DATA_W-1:0] data
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } cap_t;

    cap_t d, q;

    always_comb begin
        d       = q;
        d.valid = capture;
        if (capture) d.data = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign valid = q.valid;
    assign data  = q.data;

    // Captured word is held while no new capture happens
    p_data_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(data));
endmodule

// File: rtl/sram_seq_ctrl.sv
module sram_seq_ctrl
    import sram_seq_pkg::*;
#(
    parameter int unsigned ADDR_W   = 17,
    parameter int unsigned AA_CYC   = 2,
    parameter int unsigned OE_CYC   = 1,
    parameter int unsigned WEPW_CYC = 2,
    parameter int unsigned TURN_CYC = 1,
    parameter int unsigned DS_CYC   = 1,
    parameter int unsigned WH_CYC   = 1,
    parameter int unsigned GAP_CYC  = 1,
    parameter int unsigned CNT_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [15:0]       req_wdata,
    input  logic [1:0]        req_bmask,
    output logic              rsp_valid,
    output logic [15:0]       rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_cs1_n,
    output logic              sram_cs2,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic              sram_lb_n,
    output logic              sram_ub_n,
    output logic [15:0]       sram_dq_o,
    output logic              sram_dq_oe,
    input  logic [15:0]       sram_dq_i
);
    localparam int unsigned DATA_W   = 16;
    localparam int unsigned RD_WAIT  = max2(max2(AA_CYC, OE_CYC), 1);
    localparam int unsigned PW_REST  = (WEPW_CYC > TURN_CYC) ? (WEPW_CYC - TURN_CYC) : 1;
    localparam int unsigned DATA_CYC = max2(max2(DS_CYC, PW_REST), 1);
    localparam int unsigned TURN_E   = max2(TURN_CYC, 1);
    localparam int unsigned WH_E     = max2(WH_CYC, 1);
    localparam int unsigned GAP_E    = max2(GAP_CYC, 1);

    // Control fields are active high internally; pins are inverted at the edge
    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              cs;
        logic              oe;
        logic              we;
        logic              lb;
        logic              ub;
        logic              drv;
    } ctl_t;

    ctl_t             d, q;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_done;
    logic             cap;

    always_comb begin
        d      = q;
        t_load = 1'b0;
        t_val  = '0;
        cap    = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.addr = req_addr;
                    d.cs   = 1'b1;
                    t_load = 1'b1;
                    if (req_write) begin
                        d.st    = ST_WR_TURN;
                        d.we    = 1'b1;
                        d.oe    = 1'b0;
                        d.wdata = req_wdata;
                        d.lb    = req_bmask[0];
                        d.ub    = req_bmask[1];
                        t_val   = CNT_W'(TURN_E - 1);
                    end else begin
                        d.st  = ST_RD;
                        d.oe  = 1'b1;
                        d.lb  = 1'b1;
                        d.ub  = 1'b1;
                        t_val = CNT_W'(RD_WAIT - 1);
                    end
                end
            end
            ST_RD: begin
                if (t_done) begin
                    cap    = 1'b1;
                    d.st   = ST_RD_GAP;
                    d.cs   = 1'b0;
                    d.oe   = 1'b0;
                    d.lb   = 1'b0;
                    d.ub   = 1'b0;
                    t_load = 1'b1;
                    t_val  = CNT_W'(GAP_E - 1);
                end
            end
            ST_RD_GAP: begin
                if (t_done) d.st = ST_IDLE;
            end
            ST_WR_TURN: begin
                if (t_done) begin
                    d.st   = ST_WR_DATA;
                    d.drv  = 1'b1;
                    t_load = 1'b1;
                    t_val  = CNT_W'(DATA_CYC - 1);
                end
            end
            ST_WR_DATA: begin
                if (t_done) begin
                    d.st   = ST_WR_HOLD;
                    d.we   = 1'b0;
                    t_load = 1'b1;
                    t_val  = CNT_W'(WH_E - 1);
                end
            end
            ST_WR_HOLD: begin
                if (t_done) begin
                    d.st  = ST_IDLE;
                    d.cs  = 1'b0;
                    d.drv = 1'b0;
                    d.lb  = 1'b0;
                    d.ub  = 1'b0;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    sram_seq_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    sram_seq_rdcap #(.DATA_W(DATA_W)) u_rdcap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (cap),
        .din     (sram_dq_i),
        .valid   (rsp_valid),
        .data    (rsp_rdata)
    );

    assign req_ready  = (q.st == ST_IDLE);
    assign sram_addr  = q.addr;
    assign sram_cs1_n = ~q.cs;
    assign sram_cs2   = q.cs;
    assign sram_oe_n  = ~q.oe;
    assign sram_we_n  = ~q.we;
    assign sram_lb_n  = ~q.lb;
    assign sram_ub_n  = ~q.ub;
    assign sram_dq_o  = q.wdata;
    assign sram_dq_oe = q.drv;

    p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    p_rsp_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_oe_high_in_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> sram_oe_n);

    p_drive_after_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_dq_oe) |-> (!sram_we_n && $past(!sram_we_n)));

    p_hold_after_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_we_n) |-> (sram_dq_oe && $stable(sram_addr) && $stable(sram_dq_o)
                              && $stable(sram_lb_n) && $stable(sram_ub_n) && !sram_cs1_n));

    p_no_bus_fight_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sram_dq_oe |-> sram_oe_n);

    p_cs_pair_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sram_cs1_n == !sram_cs2);

    p_idle_deselected_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_cs1_n |-> !req_ready);
endmodule

// File: tb/sram_seq_ctrl_test.sv
module sram_seq_ctrl_test;
    localparam int AW   = 8;
    localparam int AA   = 2;
    localparam int OE   = 1;
    localparam int PW   = 3;
    localparam int TURN = 1;
    localparam int DS   = 1;
    localparam int WH   = 1;
    localparam int GAP  = 1;
    localparam int RD_WAIT = (AA > OE) ? AA : OE;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [15:0]   req_wdata = '0;
    logic [1:0]    req_bmask = '0;
    logic          rsp_valid;
    logic [15:0]   rsp_rdata;
    logic [AW-1:0] sram_addr;
    logic          sram_cs1_n, sram_cs2, sram_oe_n, sram_we_n, sram_lb_n, sram_ub_n;
    logic [15:0]   sram_dq_o;
    logic          sram_dq_oe;
    logic [15:0]   sram_dq_i;

    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    sram_seq_ctrl #(
        .ADDR_W(AW), .AA_CYC(AA), .OE_CYC(OE), .WEPW_CYC(PW), .TURN_CYC(TURN),
        .DS_CYC(DS), .WH_CYC(WH), .GAP_CYC(GAP), .CNT_W(8)
    ) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_bmask(req_bmask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_cs1_n(sram_cs1_n), .sram_cs2(sram_cs2),
        .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_lb_n(sram_lb_n),
        .sram_ub_n(sram_ub_n), .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe),
        .sram_dq_i(sram_dq_i)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                          input logic [1:0] m);
        logic [15:0] r;
        r = old;
        if (m[0]) r[7:0]  = nw[7:0];
        if (m[1]) r[15:8] = nw[15:8];
        return r;
    endfunction

    // Memory model: poison word until the access window has elapsed
    logic [15:0] mem [0:(1<<AW)-1];
    logic [15:0] ref_mem [0:(1<<AW)-1];
    int acc = 0;
    wire reading = !sram_cs1_n && sram_cs2 && !sram_oe_n && sram_we_n;
    assign sram_dq_i = (reading && acc >= RD_WAIT - 1) ? mem[sram_addr] : 16'hBAD0;

    always @(posedge clk) acc <= reading ? acc + 1 : 0;

    // Pin monitor
    logic prev_we = 1'b1, prev_drv = 1'b0, prev_sel = 1'b0, last_rd = 1'b0;
    int we_low = 0, data_cnt = 0, desel = 8, conflicts = 0;
    wire sel = !sram_cs1_n && sram_cs2;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!sram_oe_n && sram_dq_oe) conflicts++;
            if (sram_cs1_n == sram_cs2) conflicts++;
            if (sram_dq_oe && !prev_drv)
                chk(we_low >= TURN && !sram_we_n && sram_oe_n, "R4 turnaround", we_low, TURN);
            if (sram_we_n && !prev_we) begin
                chk(we_low >= PW, "R5 we pulse width", we_low, PW);
                chk(data_cnt >= DS, "R5 data setup", data_cnt, DS);
                chk(sram_dq_oe && sel, "R6 hold after we rise", {sram_dq_oe, sel}, 3);
                if (!sram_lb_n) mem[sram_addr][7:0]  = sram_dq_o[7:0];
                if (!sram_ub_n) mem[sram_addr][15:8] = sram_dq_o[15:8];
            end
            if (sel && !prev_sel) begin
                if (last_rd) chk(desel >= GAP + 1, "R8 read gap", desel, GAP + 1);
                else         chk(desel >= 1, "R8 idle between", desel, 1);
                last_rd = !sram_oe_n;
            end
            we_low   = sram_we_n ? 0 : we_low + 1;
            data_cnt = (sram_dq_oe && !sram_we_n) ? data_cnt + 1 : 0;
            desel    = sel ? 0 : desel + 1;
            prev_we  = sram_we_n;
            prev_drv = sram_dq_oe;
            prev_sel = sel;
        end
    end

    task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [15:0] dat,
                         input logic [1:0] m);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = dat; req_bmask = m;
        n = 0;
        while (!req_ready && n < 100) begin @(negedge clk); n++; end
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R2 busy after accept", req_ready, 0);
        if (wr) ref_mem[a] = merge(ref_mem[a], dat, m);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [15:0] dat, input logic [1:0] m);
        int n;
        issue(1'b1, a, dat, m);
        n = 0;
        while (!req_ready && n < 100) begin @(negedge clk); n++; end
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        int lat;
        issue(1'b0, a, 16'h0, 2'b00);
        lat = 0;
        while (!rsp_valid && lat < 100) begin @(negedge clk); lat++; end
        chk(lat == RD_WAIT, "R3 read latency", lat, RD_WAIT);
        chk(rsp_rdata == ref_mem[a], "R3 R7 read data", rsp_rdata, ref_mem[a]);
        @(negedge clk);
        chk(!rsp_valid, "R3 valid one cycle", rsp_valid, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int unsigned seed;
        logic [AW-1:0] a;
        for (int i = 0; i < (1 << AW); i++) begin mem[i] = 16'h0; ref_mem[i] = 16'h0; end
        seed = 32'd1234;
        void'($urandom(seed));
        repeat (4) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
        chk(sram_cs1_n && !sram_cs2, "R1 R10 deselected", {sram_cs1_n, sram_cs2}, 2);
        chk(sram_oe_n && sram_we_n && !sram_dq_oe, "R1 strobes",
            {sram_oe_n, sram_we_n, sram_dq_oe}, 6);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && sram_cs1_n, "R1 idle after release", {req_ready, sram_cs1_n}, 3);

        // Directed cases
        do_write(8'h10, 16'hA5C3, 2'b11);
        do_read(8'h10);
        do_write(8'h10, 16'h1177, 2'b01);     // R7 low lane only
        do_read(8'h10);
        do_write(8'h10, 16'h99EE, 2'b10);     // R7 high lane only
        do_read(8'h10);
        do_write(8'h10, 16'hFFFF, 2'b00);     // R7 no lanes
        do_read(8'h10);
        chk(ref_mem[8'h10] == 16'h9977, "R7 lane merge", ref_mem[8'h10], 16'h9977);
        do_read(8'h10);                       // R8 read then write
        do_write(8'h20, 16'h5A5A, 2'b11);
        do_read(8'h20);

        // R2: offers while busy are dropped
        issue(1'b1, 8'h30, 16'h4242, 2'b11);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 8'h31; req_wdata = 16'hDEAD; req_bmask = 2'b11;
        @(negedge clk);
        chk(!req_ready, "R2 still busy", req_ready, 0);
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        do_read(8'h31);
        chk(rsp_rdata == 16'h0000, "R2 busy offer ignored", rsp_rdata, 0);
        do_read(8'h30);

        // Random mix
        for (int k = 0; k < 300; k++) begin
            a = AW'($urandom_range(0, 15));
            if ($urandom_range(0, 1) == 1)
                do_write(a, 16'($urandom), 2'($urandom_range(0, 3)));
            else
                do_read(a);
        end

        chk(conflicts == 0, "R9 R10 no bus fight or select mismatch", conflicts, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule